// File: doc/BRIEF.md
# Interrupt Controller Setup Front End

This block is the programming side of an eight-input interrupt controller. Software reaches it through a byte-wide register bus. The bus has a chip select, one address bit that picks an "even" or an "odd" port, and separate read and write strobes. A second select reaches the per-input trigger-mode register. Before the controller does anything, software must run a start-up sequence. An even-port write with the select bit set opens the sequence. One to three odd-port writes then follow, and the number depends on two flags carried by the opening byte. Once the sequence is complete, the odd port becomes the interrupt mask register.

The block keeps the settings that the later stages of the controller need: the vector base, the cascade setting and the processor-mode bit. It also turns the eight request lines into a vector of masked pending requests. Each input is either level sensitive, where the line is passed straight through, or edge sensitive, where a rising edge is latched until a per-input clear removes it. No request is passed on until the start-up sequence has ended.

The register bus is a plain single-cycle access port. A write takes effect at the clock edge where the strobe is high. Read data is combinational in the same cycle. The port has no valid/ready handshake and never applies back-pressure, so every access completes in one cycle.

Top module: `irqc_cfg_top`

## Requirements
- R1: After reset the block is uninitialised (`init_done` = 0), the mask reads 0xFF, the trigger register reads 0x00 and `irq_pend` is 0.
- R2: A controller-port write (`bus_cs`=1, `trig_cs`=0) to the even port (`bus_addr`=0) with data bit 4 = 1 starts the sequence from any state. It clears the mask to 0x00, drops `init_done`, clears `cpu_mode`, and latches data bit 0 (fourth word wanted) and data bit 1 (single controller, no cascade word).
- R3: The first odd-port write after a sequence start loads `vector_base` with data bits 7:3.
- R4: The cascade word is the second odd-port write. It is expected only when start bit 1 was 0, and otherwise that step is skipped and `cascade_cfg` keeps its value. In the default master variant the cascade word is stored whole as a bitmap. In the slave variant only bits 2:0 (the slave ID) are stored and the upper bits read 0.
- R5: The fourth word is expected only when start bit 0 was 1, and its bit 0 sets `cpu_mode`. Without it the sequence ends after the vector or cascade word and `cpu_mode` stays 0.
- R6: `init_done` rises the cycle after the last expected word. From then on, an odd-port write loads the mask, and an odd-port read returns the mask in the same cycle.
- R7: An even-port write with data bit 4 = 0 is accepted and changes no state. An odd-port write made before any sequence start is also ignored.
- R8: Writes with `trig_cs`=1 load the trigger register, and reads with `trig_cs`=1 return it. Bit value 1 makes that input level sensitive and 0 makes it edge sensitive. While `trig_cs` is 1, the controller ports are not decoded.
- R9: A level-sensitive input that is unmasked shows on `irq_pend` in the same cycle as its line, and drops with the line.
- R10: An edge-sensitive input latches a 0-to-1 transition sampled at a clock edge, which shows on `irq_pend` after that edge. The latch holds after the line falls until `req_clr` for that input is sampled high, and the cleared state shows after that edge. An edge sampled in the same cycle as a clear wins over the clear.
- R11: `irq_pend` equals the raw requests AND NOT the mask (mask bit 1 blocks the input), and it is all zero while `init_done` is 0.
- R12: An even-port read returns the raw, unmasked request vector. When no read is strobed, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Controller port select |
| bus_addr | input | 1 | Port select: 0 even, 1 odd |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| trig_cs | input | 1 | Trigger-mode register select |
| irq_in | input | 8 | Request lines |
| req_clr | input | 8 | Per-input clear of latched edge requests |
| irq_pend | output | 8 | Masked pending requests |
| init_done | output | 1 | Start-up sequence complete |
| vector_base | output | 5 | Vector base from the vector word |
| cascade_cfg | output | 8 | Cascade bitmap (master) or slave ID |
| cpu_mode | output | 1 | Processor-mode bit from the fourth word |

## Verification
Some properties are checked on every cycle. No masked input ever appears on `irq_pend`, and the output stays quiet before initialisation. A sequence start always leaves the mask clear and the block uninitialised. Mask and trigger writes land in the next cycle, `init_done` can rise only after an odd-port write, and level inputs track their lines. Other behaviours need multi-write scenarios and can only be shown by the bench: the word-skipping that depends on the start flags, a restart part-way through a sequence, ignored writes, read-back values, and the edge-latch timing against clears.

// File: rtl/irqc_cfg_pkg.sv
package irqc_cfg_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_VEC,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_READY
  } seq_e;

  localparam int START_BIT    = 4;
  localparam int WANT4_BIT    = 0;
  localparam int SINGLE_BIT   = 1;
  localparam int MODE_BIT     = 0;
  localparam int VEC_LSB      = 3;
endpackage

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit IS_SLAVE = 1'b0,
  parameter int SID_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_even,
  input  logic                      wr_odd,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         mask_q,
  output logic                      init_done,
  output logic [DATA_W-VEC_LSB-1:0] vector_base,
  output logic [DATA_W-1:0]         cascade_cfg,
  output logic                      cpu_mode
);
  seq_e        state_q;
  logic        want4_q;
  logic        single_q;
  logic [DATA_W-1:0] casc_in;
  logic        start_hit;

  generate
    if (IS_SLAVE) begin : g_slave
      assign casc_in = {{(DATA_W-SID_W){1'b0}}, wdata[SID_W-1:0]};
    end else begin : g_master
      assign casc_in = wdata;
    end
  endgenerate

  assign start_hit = wr_even && wdata[START_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      want4_q     <= 1'b0;
      single_q    <= 1'b0;
      mask_q      <= '1;
      vector_base <= '0;
      cascade_cfg <= '0;
      cpu_mode    <= 1'b0;
    end else if (start_hit) begin
      state_q  <= SEQ_VEC;
      want4_q  <= wdata[WANT4_BIT];
      single_q <= wdata[SINGLE_BIT];
      mask_q   <= '0;
      cpu_mode <= 1'b0;
    end else if (wr_odd) begin
      case (state_q)
        SEQ_VEC: begin
          vector_base <= wdata[DATA_W-1:VEC_LSB];
          if (!single_q)    state_q <= SEQ_CASC;
          else if (want4_q) state_q <= SEQ_MODE;
          else              state_q <= SEQ_READY;
        end
        SEQ_CASC: begin
          cascade_cfg <= casc_in;
          state_q     <= want4_q ? SEQ_MODE : SEQ_READY;
        end
        SEQ_MODE: begin
          cpu_mode <= wdata[MODE_BIT];
          state_q  <= SEQ_READY;
        end
        SEQ_READY: mask_q <= wdata;
        default: ;
      endcase
    end
  end

  assign init_done = (state_q == SEQ_READY);
endmodule

// File: rtl/irqc_trig_reg.sv
module irqc_trig_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)  level_sel <= '0;
    else if (we) level_sel <= wdata;
  end
endmodule

// File: rtl/irqc_reqpath.sv
module irqc_reqpath #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] req_clr,
  input  logic [N_IRQ-1:0] level_sel,
  input  logic [N_IRQ-1:0] mask,
  input  logic             enable,
  output logic [N_IRQ-1:0] raw_req,
  output logic [N_IRQ-1:0] pend
);
  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_in
      logic prev_q;
      logic edge_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          edge_q <= 1'b0;
        end else begin
          prev_q <= irq_in[i];
          if (level_sel[i]) edge_q <= 1'b0;
          else edge_q <= (edge_q && !req_clr[i]) || (irq_in[i] && !prev_q);
        end
      end

      assign raw_req[i] = level_sel[i] ? irq_in[i] : edge_q;
      assign pend[i]    = enable && raw_req[i] && !mask[i];
    end
  endgenerate
endmodule

// File: rtl/irqc_cfg_top.sv
module irqc_cfg_top #(
  parameter int DATA_W   = 8,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trig_cs,
  input  logic [DATA_W-1:0] irq_in,
  input  logic [DATA_W-1:0] req_clr,
  output logic [DATA_W-1:0] irq_pend,
  output logic              init_done,
  output logic [DATA_W-4:0] vector_base,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic              cpu_mode
);
  logic              pic_acc;
  logic              wr_even;
  logic              wr_odd;
  logic              trig_we;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] trig_q;
  logic [DATA_W-1:0] raw_req;

  assign pic_acc = bus_cs && !trig_cs;
  assign wr_even = pic_acc && bus_wr && !bus_addr;
  assign wr_odd  = pic_acc && bus_wr && bus_addr;
  assign trig_we = trig_cs && bus_wr;

  irqc_seq #(.DATA_W(DATA_W), .IS_SLAVE(IS_SLAVE)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_even     (wr_even),
    .wr_odd      (wr_odd),
    .wdata       (bus_wdata),
    .mask_q      (mask_q),
    .init_done   (init_done),
    .vector_base (vector_base),
    .cascade_cfg (cascade_cfg),
    .cpu_mode    (cpu_mode)
  );

  irqc_trig_reg #(.DATA_W(DATA_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (trig_we),
    .wdata     (bus_wdata),
    .level_sel (trig_q)
  );

  irqc_reqpath #(.N_IRQ(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .req_clr   (req_clr),
    .level_sel (trig_q),
    .mask      (mask_q),
    .enable    (init_done),
    .raw_req   (raw_req),
    .pend      (irq_pend)
  );

  always_comb begin
    if (trig_cs && bus_rd)     bus_rdata = trig_q;
    else if (pic_acc && bus_rd) bus_rdata = bus_addr ? mask_q : raw_req;
    else                       bus_rdata = '0;
  end
endmodule

// File: rtl/irqc_cfg_chk.sv
module irqc_cfg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              trig_cs,
  input logic [DATA_W-1:0] irq_in,
  input logic [DATA_W-1:0] irq_pend,
  input logic              init_done,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] trig_q
);
  logic ctl_wr;
  assign ctl_wr = bus_cs && !trig_cs && bus_wr;

  a_r11_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & mask_q) == '0);

  a_r11_quiet_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> irq_pend == '0);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_addr && bus_wdata[4]) |=> (mask_q == '0 && !init_done));

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && ctl_wr && bus_addr) |=> mask_q == $past(bus_wdata));

  a_r6_done_after_odd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ctl_wr && bus_addr));

  a_r8_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_cs && bus_wr) |=> trig_q == $past(bus_wdata));

  a_r9_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ((irq_pend ^ (irq_in & ~mask_q)) & trig_q) == '0);
endmodule

bind irqc_cfg_top irqc_cfg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .trig_cs   (trig_cs),
  .irq_in    (irq_in),
  .irq_pend  (irq_pend),
  .init_done (init_done),
  .mask_q    (mask_q),
  .trig_q    (trig_q)
);

// File: tb/irqc_cfg_top_bench.sv
module irqc_cfg_top_bench;
  localparam int K_RDATA = 0, K_PEND = 1, K_INIT = 2, K_VBASE = 3, K_CASC = 4, K_CPU = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 0, bus_addr = 0, bus_wr = 0, bus_rd = 0, trig_cs = 0;
  logic [7:0] bus_wdata = '0, irq_in = '0, req_clr = '0;
  logic [7:0] bus_rdata, irq_pend, cascade_cfg;
  logic [4:0] vector_base;
  logic       init_done, cpu_mode;

  int  n_chk = 0, n_err = 0;
  bit  done_f = 0;
  int         kind_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       ev_chk;

  always #10 clk = ~clk;

  irqc_cfg_top u_irqc_cfg_top (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_cs(trig_cs), .irq_in(irq_in), .req_clr(req_clr), .irq_pend(irq_pend),
    .init_done(init_done), .vector_base(vector_base), .cascade_cfg(cascade_cfg),
    .cpu_mode(cpu_mode)
  );

  task automatic expect_v(input int kind, input logic [7:0] exp, input string tag);
    kind_q.push_back(kind);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> ev_chk;
  endtask

  // monitor: pops expected items and compares with the observed port
  initial begin
    forever begin
      @(ev_chk);
      while (kind_q.size() > 0) begin
        int         k;
        logic [7:0] e, act;
        string      t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case (k)
          K_RDATA: act = bus_rdata;
          K_PEND:  act = irq_pend;
          K_INIT:  act = {7'd0, init_done};
          K_VBASE: act = {3'd0, vector_base};
          K_CASC:  act = cascade_cfg;
          default: act = {7'd0, cpu_mode};
        endcase
        n_chk++;
        if (act !== e) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  task automatic chk(input int kind, input logic [7:0] exp, input string tag);
    #1;
    expect_v(kind, exp, tag);
  endtask

  task automatic do_write(input logic trig, input logic addr, input logic [7:0] d);
    @(negedge clk);
    trig_cs = trig; bus_cs = !trig; bus_addr = addr; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    trig_cs = 1'b0; bus_cs = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic chk_read(input logic trig, input logic addr, input logic [7:0] exp,
                          input string tag);
    @(negedge clk);
    trig_cs = trig; bus_cs = !trig; bus_addr = addr; bus_rd = 1'b1;
    #1;
    expect_v(K_RDATA, exp, tag);
    #1;
    trig_cs = 1'b0; bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done_f) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk(K_INIT, 8'h00, "R1 init_done after reset");
    chk(K_PEND, 8'h00, "R1 pend after reset");
    chk_read(1'b0, 1'b1, 8'hFF, "R1 mask after reset");
    chk_read(1'b1, 1'b0, 8'h00, "R1 trigger after reset");
    // odd write before any start is ignored
    do_write(1'b0, 1'b1, 8'h12);
    chk_read(1'b0, 1'b1, 8'hFF, "R7 odd write before start");
    // full sequence with cascade and fourth word
    do_write(1'b0, 1'b0, 8'h11);
    chk(K_INIT, 8'h00, "R2 start drops init");
    chk_read(1'b0, 1'b1, 8'h00, "R2 start clears mask");
    do_write(1'b0, 1'b1, 8'h40);
    chk(K_VBASE, 8'h08, "R3 vector base");
    do_write(1'b0, 1'b1, 8'h04);
    chk(K_CASC, 8'h04, "R4 cascade bitmap");
    chk(K_INIT, 8'h00, "R5 waiting for fourth word");
    do_write(1'b0, 1'b1, 8'h01);
    chk(K_CPU, 8'h01, "R5 cpu mode set");
    chk(K_INIT, 8'h01, "R6 init done");
    // even write without start bit ignored
    do_write(1'b0, 1'b0, 8'h20);
    chk(K_INIT, 8'h01, "R7 ignored even write keeps init");
    chk(K_VBASE, 8'h08, "R7 ignored even write keeps vector");
    chk_read(1'b0, 1'b1, 8'h00, "R7 ignored even write keeps mask");
    do_write(1'b0, 1'b1, 8'hFB);
    chk_read(1'b0, 1'b1, 8'hFB, "R6 mask readback");
    // trigger register
    do_write(1'b1, 1'b0, 8'h0F);
    chk_read(1'b1, 1'b0, 8'h0F, "R8 trigger readback");
    chk_read(1'b0, 1'b1, 8'hFB, "R8 trigger write leaves mask");
    // level inputs
    do_write(1'b0, 1'b1, 8'h00);
    @(negedge clk); irq_in = 8'h05;
    chk(K_PEND, 8'h05, "R9 level same cycle");
    chk_read(1'b0, 1'b0, 8'h05, "R12 raw read");
    @(negedge clk); irq_in = 8'h00;
    chk(K_PEND, 8'h00, "R9 level drops");
    // edge input 4
    @(negedge clk); irq_in = 8'h10;
    chk(K_PEND, 8'h00, "R10 edge not before clock");
    @(negedge clk);
    chk(K_PEND, 8'h10, "R10 edge latched");
    @(negedge clk); irq_in = 8'h00;
    chk(K_PEND, 8'h10, "R10 edge held after line falls");
    @(negedge clk); req_clr = 8'h10;
    chk(K_PEND, 8'h10, "R10 clear not before clock");
    @(negedge clk); req_clr = 8'h00;
    chk(K_PEND, 8'h00, "R10 cleared");
    // edge and clear in same cycle
    @(negedge clk); irq_in = 8'h20; req_clr = 8'h20;
    @(negedge clk); req_clr = 8'h00;
    chk(K_PEND, 8'h20, "R10 edge wins over clear");
    @(negedge clk); irq_in = 8'h00; req_clr = 8'h20;
    @(negedge clk); req_clr = 8'h00;
    chk(K_PEND, 8'h00, "R10 later clear");
    // mask blocks
    do_write(1'b0, 1'b1, 8'h01);
    @(negedge clk); irq_in = 8'h01;
    chk(K_PEND, 8'h00, "R11 masked input blocked");
    chk_read(1'b0, 1'b0, 8'h01, "R12 raw ignores mask");
    // restart part-way
    do_write(1'b0, 1'b0, 8'h13);
    chk(K_INIT, 8'h00, "R2 restart drops init");
    chk(K_PEND, 8'h00, "R11 quiet while uninitialised");
    chk(K_CPU, 8'h00, "R2 restart clears cpu mode");
    do_write(1'b0, 1'b1, 8'h88);
    chk(K_VBASE, 8'h11, "R3 vector base second");
    do_write(1'b0, 1'b0, 8'h10);
    chk(K_INIT, 8'h00, "R2 mid-sequence restart");
    do_write(1'b0, 1'b1, 8'h68);
    chk(K_VBASE, 8'h0D, "R3 vector after restart");
    do_write(1'b0, 1'b1, 8'h02);
    chk(K_CASC, 8'h02, "R4 cascade after restart");
    chk(K_INIT, 8'h01, "R5 done without fourth word");
    chk(K_CPU, 8'h00, "R5 cpu mode stays 0");
    chk(K_PEND, 8'h01, "R11 pend after init with mask 0");
    // single: cascade word skipped
    do_write(1'b0, 1'b0, 8'h13);
    do_write(1'b0, 1'b1, 8'h48);
    chk(K_VBASE, 8'h09, "R3 vector single");
    do_write(1'b0, 1'b1, 8'h01);
    chk(K_CASC, 8'h02, "R4 cascade skipped keeps value");
    chk(K_CPU, 8'h01, "R5 fourth word after skip");
    chk(K_INIT, 8'h01, "R4 init after skip");
    // single and no fourth word
    do_write(1'b0, 1'b0, 8'h12);
    do_write(1'b0, 1'b1, 8'h30);
    chk(K_INIT, 8'h01, "R5 done after vector only");
    chk(K_VBASE, 8'h06, "R3 vector only");
    chk(K_CPU, 8'h00, "R5 cpu cleared");
    // read gating
    @(negedge clk);
    chk(K_RDATA, 8'h00, "R12 no read gives zero");
    do_write(1'b0, 1'b1, 8'h5A);
    chk_read(1'b0, 1'b1, 8'h5A, "R6 mask readback second");
    repeat (3) @(negedge clk);
    done_f = 1'b1;
    summary();
    $finish;
  end
endmodule